// File: doc/BRIEF.md
# Seven-to-one pixel serial link

The block turns one parallel video pixel into six serial streams and restores it on the far side. A pixel here is a 10-bit red, green and blue value, horizontal sync, vertical sync, data enable and two spare bits. The transmit half takes one pixel every seven fast-clock cycles. It spreads the 35 bits over five data lanes of seven slots each. A sixth lane carries a fixed framing pattern that stands in for the pixel clock. All lanes are single-ended bits at seven times the pixel rate, meant to feed a later differential driver.

The receive half shifts the six incoming streams into seven-deep histories. When the framing lane's history shows the complete pattern, it decodes the five data lanes back into a pixel and marks that pixel valid for one cycle. For a loopback test, the transmit lanes connect to the receive lanes. Both halves run on the one fast clock. The transmitter raises a load strobe in the cycle whose closing edge captures the next pixel.

Top module: `lvds_pixel_link`

## Requirements
- R1: While reset is asserted, every transmit lane and the framing lane are 0, the receive valid flag and receive pixel are 0, and the load strobe is 1. The first clock edge after reset is released captures a pixel.
- R2: The load strobe is high for one cycle out of every seven. The pixel inputs are sampled at the clock edge that ends a strobe cycle.
- R3: Data lane 0 sends, slot by slot, red bits 0 to 5 and then green bit 0.
- R4: Data lane 1 sends green bits 1 to 5, then blue bit 0, then blue bit 1.
- R5: Data lane 2 sends blue bits 2 to 5, then horizontal sync, vertical sync and data enable.
- R6: Data lane 3 sends red 6, red 7, green 6, green 7, blue 6, blue 7, then spare bit 0.
- R7: Data lane 4 sends blue 8, blue 9, green 8, green 9, red 8, red 9, then spare bit 1.
- R8: Slot 0 of a captured pixel is on the lanes in the cycle right after the capture edge. Each later slot follows one cycle apart, so the seven slots fill exactly one strobe period.
- R9: The framing lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period.
- R10: When the last seven framing-lane samples, oldest first, read 1,1,0,0,0,1,1, the receiver decodes the same seven samples of each data lane and presents the pixel with valid high for that one cycle. In loopback, that pixel appears eight cycles after its strobe cycle.
- R11: If the framing pattern is missing from the last seven samples, valid stays low and the receive pixel outputs hold the last decoded pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_red | input | 10 | Red component to send |
| px_grn | input | 10 | Green component to send |
| px_blu | input | 10 | Blue component to send |
| px_hsync | input | 1 | Horizontal sync to send |
| px_vsync | input | 1 | Vertical sync to send |
| px_de | input | 1 | Data enable to send |
| px_spare | input | 2 | Spare bits to send |
| px_load | output | 1 | High in the cycle whose closing edge captures the pixel |
| tx_data | output | 5 | Serial data lanes, bit n is lane n |
| tx_frame | output | 1 | Serial framing lane |
| rx_data | input | 5 | Received data lanes |
| rx_frame | input | 1 | Received framing lane |
| rx_valid | output | 1 | One-cycle pulse when a pixel is decoded |
| rx_red | output | 10 | Decoded red |
| rx_grn | output | 10 | Decoded green |
| rx_blu | output | 10 | Decoded blue |
| rx_hsync | output | 1 | Decoded horizontal sync |
| rx_vsync | output | 1 | Decoded vertical sync |
| rx_de | output | 1 | Decoded data enable |
| rx_spare | output | 2 | Decoded spare bits |

## Verification
The receive-side assertions assume that valid follows a sample of 1 on the framing lane. They also assume that two decodes can never be adjacent, which holds for any input sequence because the pattern differs from each of its shifts. The transmit-side checks assume that the strobe rhythm is never disturbed after reset. The bench never touches the data lanes. It only breaks the framing lane, by holding it low over whole pixel periods that line up with slot boundaries, so that every seven-sample window is either fully clean or fully broken. Pixels are random, with a few directed extremes mixed in: all zeros, all ones, alternating bits, a lone sync bit and lone spare bits.

// File: rtl/lvds_link_pkg.sv
package lvds_link_pkg;
    localparam int COLOR_W = 10;
    localparam int LANES   = 5;
    localparam int SLOTS   = 7;
    localparam int SLOT_CW = $clog2(SLOTS);
    // framing lane pattern, bit i goes out in slot i
    localparam logic [SLOTS-1:0] FRAME_PAT = 7'b1100011;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               hs;
        logic               vs;
        logic               de;
        logic [1:0]         spare;
    } pixel_t;

    typedef logic [SLOTS-1:0]              slot_word_t;
    typedef slot_word_t [LANES-1:0]        lane_words_t;

    // bit 0 of each word is the slot sent first
    function automatic lane_words_t pack_pixel(input pixel_t p);
        lane_words_t w;
        w[0] = {p.grn[0], p.red[5:0]};
        w[1] = {p.blu[1:0], p.grn[5:1]};
        w[2] = {p.de, p.vs, p.hs, p.blu[5:2]};
        w[3] = {p.spare[0], p.blu[7], p.blu[6], p.grn[7], p.grn[6], p.red[7], p.red[6]};
        w[4] = {p.spare[1], p.red[9], p.red[8], p.grn[9], p.grn[8], p.blu[9], p.blu[8]};
        return w;
    endfunction

    function automatic pixel_t unpack_pixel(input lane_words_t w);
        pixel_t p;
        p.red   = {w[4][5], w[4][4], w[3][1], w[3][0], w[0][5:0]};
        p.grn   = {w[4][3], w[4][2], w[3][3], w[3][2], w[1][4:0], w[0][6]};
        p.blu   = {w[4][1], w[4][0], w[3][5], w[3][4], w[2][3:0], w[1][6:5]};
        p.hs    = w[2][4];
        p.vs    = w[2][5];
        p.de    = w[2][6];
        p.spare = {w[4][6], w[3][6]};
        return p;
    endfunction
endpackage

// File: rtl/pix_serializer.sv
module pix_serializer
    import lvds_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pixel_t           pix_i,
    output logic             load_o,
    output logic [LANES-1:0] lane_o,
    output logic             frame_o
);
    typedef struct packed {
        logic [SLOT_CW-1:0] slot;
        lane_words_t        sh;
        slot_word_t         fsh;
    } ser_state_t;

    ser_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.slot == SLOT_CW'(SLOTS-1)) begin
            s_d.slot = '0;
            s_d.sh   = pack_pixel(pix_i);
            s_d.fsh  = FRAME_PAT;
        end else begin
            s_d.slot = s_q.slot + SLOT_CW'(1);
            for (int i = 0; i < LANES; i++) begin
                s_d.sh[i] = s_q.sh[i] >> 1;
            end
            s_d.fsh = s_q.fsh >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.slot <= SLOT_CW'(SLOTS-1);
            s_q.sh   <= '0;
            s_q.fsh  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o  = (s_q.slot == SLOT_CW'(SLOTS-1));
    assign frame_o = s_q.fsh[0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_o[g] = s_q.sh[g][0];
    end

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
    p_frame_first_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> frame_o);
endmodule

// File: rtl/pix_deserializer.sv
module pix_deserializer
    import lvds_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_i,
    input  logic             frame_i,
    output logic             valid_o,
    output pixel_t           pix_o
);
    typedef struct packed {
        lane_words_t hist;
        slot_word_t  fhist;
        logic        valid;
        pixel_t      pix;
    } des_state_t;

    des_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < LANES; i++) begin
            s_d.hist[i] = {lane_i[i], s_q.hist[i][SLOTS-1:1]};
        end
        s_d.fhist = {frame_i, s_q.fhist[SLOTS-1:1]};
        s_d.valid = (s_d.fhist == FRAME_PAT);
        if (s_d.valid) begin
            s_d.pix = unpack_pixel(s_d.hist);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.valid;
    assign pix_o   = s_q.pix;

    p_valid_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_valid_after_frame_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(frame_i));
    p_hold_without_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(pix_o));
endmodule

// File: rtl/lvds_pixel_link.sv
module lvds_pixel_link
    import lvds_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COLOR_W-1:0] px_red,
    input  logic [COLOR_W-1:0] px_grn,
    input  logic [COLOR_W-1:0] px_blu,
    input  logic               px_hsync,
    input  logic               px_vsync,
    input  logic               px_de,
    input  logic [1:0]         px_spare,
    output logic               px_load,
    output logic [LANES-1:0]   tx_data,
    output logic               tx_frame,
    input  logic [LANES-1:0]   rx_data,
    input  logic               rx_frame,
    output logic               rx_valid,
    output logic [COLOR_W-1:0] rx_red,
    output logic [COLOR_W-1:0] rx_grn,
    output logic [COLOR_W-1:0] rx_blu,
    output logic               rx_hsync,
    output logic               rx_vsync,
    output logic               rx_de,
    output logic [1:0]         rx_spare
);
    pixel_t tx_pix, rx_pix;

    always_comb begin
        tx_pix.red   = px_red;
        tx_pix.grn   = px_grn;
        tx_pix.blu   = px_blu;
        tx_pix.hs    = px_hsync;
        tx_pix.vs    = px_vsync;
        tx_pix.de    = px_de;
        tx_pix.spare = px_spare;
    end

    pix_serializer u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_i   (tx_pix),
        .load_o  (px_load),
        .lane_o  (tx_data),
        .frame_o (tx_frame)
    );

    pix_deserializer u_des (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_i  (rx_data),
        .frame_i (rx_frame),
        .valid_o (rx_valid),
        .pix_o   (rx_pix)
    );

    assign rx_red   = rx_pix.red;
    assign rx_grn   = rx_pix.grn;
    assign rx_blu   = rx_pix.blu;
    assign rx_hsync = rx_pix.hs;
    assign rx_vsync = rx_pix.vs;
    assign rx_de    = rx_pix.de;
    assign rx_spare = rx_pix.spare;
endmodule

// File: tb/sim_lvds_pixel_link.sv
module sim_lvds_pixel_link;
    localparam int NCYC = 2500;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] px_red, px_grn, px_blu;
    logic       px_hsync, px_vsync, px_de;
    logic [1:0] px_spare;
    logic       px_load;
    logic [4:0] tx_data;
    logic       tx_frame;
    logic       rx_valid;
    logic [9:0] rx_red, rx_grn, rx_blu;
    logic       rx_hsync, rx_vsync, rx_de;
    logic [1:0] rx_spare;
    logic       corrupt;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    lvds_pixel_link u0 (
        .clk(clk), .rst_n(rst_n),
        .px_red(px_red), .px_grn(px_grn), .px_blu(px_blu),
        .px_hsync(px_hsync), .px_vsync(px_vsync), .px_de(px_de), .px_spare(px_spare),
        .px_load(px_load), .tx_data(tx_data), .tx_frame(tx_frame),
        .rx_data(tx_data), .rx_frame(corrupt ? 1'b0 : tx_frame),
        .rx_valid(rx_valid), .rx_red(rx_red), .rx_grn(rx_grn), .rx_blu(rx_blu),
        .rx_hsync(rx_hsync), .rx_vsync(rx_vsync), .rx_de(rx_de), .rx_spare(rx_spare)
    );

    // flat pixel: red 0..9, green 10..19, blue 20..29, hs 30, vs 31, de 32, spare 33..34
    function automatic logic [34:0] flat(input logic [9:0] r, g, b, input logic hs, vs, de,
                                         input logic [1:0] sp);
        return {sp, de, vs, hs, b, g, r};
    endfunction

    // which flat bit a lane carries in a slot
    function automatic int src_bit(input int lane, input int slot);
        int t0 [7] = '{0, 1, 2, 3, 4, 5, 10};
        int t1 [7] = '{11, 12, 13, 14, 15, 20, 21};
        int t2 [7] = '{22, 23, 24, 25, 30, 31, 32};
        int t3 [7] = '{6, 7, 16, 17, 26, 27, 33};
        int t4 [7] = '{28, 29, 18, 19, 8, 9, 34};
        case (lane)
            0: return t0[slot];
            1: return t1[slot];
            2: return t2[slot];
            3: return t3[slot];
            default: return t4[slot];
        endcase
    endfunction

    function automatic logic frame_bit(input int slot);
        return (slot <= 1) || (slot >= 5);
    endfunction

    function automatic string lane_req(input int lane);
        case (lane)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [34:0] v);
        {px_spare, px_de, px_vsync, px_hsync, px_blu, px_grn, px_red} = v;
    endtask

    initial begin
        #(NCYC * 10 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic [34:0] cur_v, prev_v, held, rxv, nv;
        int cur_l, prev_l, first_l, k, c_lo, c_hi;
        bit have_cur, have_prev, exp_valid;
        seed_v = $urandom(32'd20240611);
        cur_v = '0; prev_v = '0; held = '0;
        cur_l = -100; prev_l = -100; first_l = -1; k = 0;
        c_lo = -1000; c_hi = -1000;
        have_cur = 0; have_prev = 0;
        corrupt = 1'b0;
        rst_n = 1'b0;
        drive('0);
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(tx_data == 5'd0 && tx_frame == 1'b0, "R1 lanes idle", {tx_frame, tx_data}, 0);
        check(rx_valid == 1'b0, "R1 rx idle", rx_valid, 0);
        check(px_load == 1'b1, "R1 strobe", px_load, 1);
        rst_n = 1'b1;
        for (int n = 0; n < NCYC; n++) begin
            if (n > 0) @(negedge clk);
            corrupt = (n >= c_lo && n <= c_hi);
            if (n == 0) check(px_load == 1'b1, "R1 first capture", px_load, 1);
            if (first_l >= 0)
                check(px_load == (((n - first_l) % 7) == 0), "R2 strobe period", px_load,
                      ((n - first_l) % 7) == 0);
            // lane contents, R8 slot timing
            if (have_cur && n - cur_l >= 1 && n - cur_l <= 7) begin
                int s;
                s = n - cur_l - 1;
                for (int l = 0; l < 5; l++)
                    check(tx_data[l] == cur_v[src_bit(l, s)], {lane_req(l), " R8 slot"},
                          tx_data[l], cur_v[src_bit(l, s)]);
                check(tx_frame == frame_bit(s), "R9 frame lane", tx_frame, frame_bit(s));
            end else if (!have_cur) begin
                check(tx_data == 5'd0 && tx_frame == 1'b0, "R1 idle before load",
                      {tx_frame, tx_data}, 0);
            end
            // receive side
            exp_valid = have_prev && (n == prev_l + 8) && (prev_l + 7 < c_lo || prev_l + 1 > c_hi);
            rxv = flat(rx_red, rx_grn, rx_blu, rx_hsync, rx_vsync, rx_de, rx_spare);
            if (n >= c_lo && n <= c_hi + 8)
                check(rx_valid == exp_valid, "R11 valid under broken frame", rx_valid, exp_valid);
            else
                check(rx_valid == exp_valid, "R10 valid timing", rx_valid, exp_valid);
            if (rx_valid && exp_valid) begin
                check(rxv == prev_v, "R10 decoded pixel", rxv, prev_v);
                held = rxv;
            end else if (!rx_valid) begin
                check(rxv == held, "R11 hold", rxv, held);
            end
            // new pixel
            if (px_load) begin
                case (k)
                    0: nv = '0;
                    1: nv = '1;
                    2: nv = 35'h2_AAAA_AAAA;
                    3: nv = 35'h0_4000_0000;
                    4: nv = 35'h6_0000_0000;
                    default: nv = {$urandom, $urandom} & 35'h7_FFFF_FFFF;
                endcase
                if (k == 60) begin
                    c_lo = n + 1;
                    c_hi = n + 14;
                end
                drive(nv);
                if (first_l < 0) first_l = n;
                prev_v = cur_v; prev_l = cur_l; have_prev = have_cur;
                cur_v = nv; cur_l = n; have_cur = 1;
                k++;
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule